// File: doc/BRIEF.md
# Daisy-Chainable SPI Target Shift Register

This block is the target end of an SPI link. Its serial clock, data-in and active-low select pins are brought into the system clock domain through synchronizer flops. A runtime choice of clock polarity and clock phase sets which serial clock edge captures incoming bits and which edge moves the outgoing line. Received bits are shifted most-significant first into an 8-bit register. Each completed byte appears on a parallel output together with a one-cycle valid strobe. A parallel load port supplies the byte that is sent back.

With chain mode enabled, the block re-sends, unchanged, the byte it received in the previous group of eight clock pulses. A string of these targets then behaves as one long shift register between the first data-in and the last data-out. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_chain_tgt`

## Requirements
- R1: While reset is asserted and just after it, data-out, the valid strobe and the received-byte output are all 0.
- R2: The capture edge follows the selected mode. With phase 0 it is the leading edge, and with phase 1 it is the trailing edge. The leading edge is the rising edge for polarity 0 and the falling edge for polarity 1.
- R3: Bits are captured most-significant first. On the eighth capture edge of a group, the received-byte output takes the byte and the valid strobe is high for exactly one system clock.
- R4: With phase 0, a falling edge on select puts the first (most-significant) bit of the outgoing byte on data-out before any clock edge. Later bits change on trailing edges. The trailing edge after the eighth capture presents the first bit of the next group.
- R5: With phase 1, data-out changes only on leading edges. After the last leading edge of a transfer it holds its final bit until select rises.
- R6: While select is high, serial clock edges are ignored. Data-out, the received-byte output and the valid strobe do not change.
- R7: If select rises before eight capture edges, the partial byte is dropped and no valid strobe is raised. The next select fall starts again at bit 0.
- R8: With chain mode off, each group sends the byte last written on the load port. All-zero bits are sent if nothing has been loaded since reset.
- R9: With chain mode on, each group sends the byte received in the group before it, including one received in an earlier select period. This is 0 if no byte has been received since reset.
- R10: An input pin change that the system clock first samples at one edge updates the outputs on the second edge after it (two synchronizer flops, then registered outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level (polarity) |
| cpha_i | input | 1 | Clock phase: 0 = capture on leading edge, 1 = capture on trailing edge |
| chain_en_i | input | 1 | 1 = echo the previous received byte, 0 = send the loaded byte |
| sclk_i | input | 1 | Serial clock from the controller, asynchronous |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| sdi_i | input | 1 | Serial data into the target |
| sdo_o | output | 1 | Serial data out of the target |
| tx_data_i | input | 8 | Byte to send when chain mode is off |
| tx_load_i | input | 1 | Writes tx_data_i into the transmit holding register |
| rx_data_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe when rx_data_o takes a new byte |

## Verification
Single-byte transfers run in all four polarity and phase combinations, each with a different pair of received and sent bytes. Those pairs catch a swapped capture or launch edge, reversed bit order, and a first bit that is not ready at the select fall. A transfer before any load shows that the all-zero default is used. A 16-bit select period separates reloading at the byte boundary from reloading only once per select period. Clock toggling with select high, and a 5-bit aborted frame followed by a full one, separate true idling from shifting that is merely hidden. Chained 24-bit and 8-bit frames show whether the echo comes from the previous group or from the current one. A cycle-accurate reference model compared on every system clock pins down the two-flop input latency.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic sdi;
  } pin_bus_t;

  localparam int PIN_W = $bits(pin_bus_t);

  localparam pin_bus_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

  // Choose the rising or falling pulse for the leading or trailing edge.
  function automatic logic pick_edge(input logic cpol, input logic want_lead,
                                     input logic rise, input logic fall);
    return (want_lead ^ cpol) ? rise : fall;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= {STAGES{RST_VAL[g]}};
      else        stage_q <= {stage_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = stage_q[STAGES-1];
  end

endmodule

// File: rtl/spi_edge_decode.sv
module spi_edge_decode
  import spi_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_bus_t pins_s,
  input  logic     cpol,
  input  logic     cpha,
  output logic     ev_sample,
  output logic     ev_launch,
  output logic     ev_cs_fall,
  output logic     ev_cs_rise,
  output logic     sel_active,
  output logic     sdi_bit
);

  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= PIN_IDLE.sclk;
      cs_q   <= PIN_IDLE.cs_n;
    end else begin
      sclk_q <= pins_s.sclk;
      cs_q   <= pins_s.cs_n;
    end
  end

  logic sclk_rise, sclk_fall, lead_ev, trail_ev;

  assign sclk_rise  = pins_s.sclk & ~sclk_q;
  assign sclk_fall  = ~pins_s.sclk & sclk_q;
  assign lead_ev    = pick_edge(cpol, 1'b1, sclk_rise, sclk_fall);
  assign trail_ev   = pick_edge(cpol, 1'b0, sclk_rise, sclk_fall);

  assign sel_active = ~pins_s.cs_n;
  assign ev_cs_fall = ~pins_s.cs_n & cs_q;
  assign ev_cs_rise = pins_s.cs_n & ~cs_q;
  assign ev_sample  = sel_active & (cpha ? trail_ev : lead_ev);
  assign ev_launch  = sel_active & (cpha ? lead_ev : trail_ev);
  assign sdi_bit    = pins_s.sdi;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              chain_en,
  input  logic              ev_sample,
  input  logic              ev_launch,
  input  logic              ev_cs_fall,
  input  logic              ev_cs_rise,
  input  logic              sel_active,
  input  logic              sdi_bit,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ev_byte_done,
  output logic              frame_src_msb
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] pick_src(input logic chain,
                                                 input logic [DATA_W-1:0] echo,
                                                 input logic [DATA_W-1:0] held);
    return chain ? echo : held;
  endfunction

  function automatic logic [DATA_W-1:0] shift_up(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, tx_hold, echo_buf, rx_next, frame_src, byte_src;
  logic              last_bit;

  assign last_bit      = (bit_cnt == LAST_IDX);
  assign rx_next       = {rx_sh[DATA_W-2:0], sdi_bit};
  assign frame_src     = pick_src(chain_en, echo_buf, tx_hold);
  assign byte_src      = pick_src(chain_en, rx_next, tx_hold);
  assign frame_src_msb = frame_src[DATA_W-1];
  assign ev_byte_done  = sel_active & ev_sample & last_bit & ~ev_cs_fall & ~ev_cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_hold <= '0;
    else if (tx_load) tx_hold <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      echo_buf <= '0;
      sdo      <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (ev_cs_fall) begin
        bit_cnt <= '0;
        if (!cpha) begin
          sdo   <= frame_src[DATA_W-1];
          tx_sh <= shift_up(frame_src);
        end else begin
          tx_sh <= frame_src;
        end
      end else if (ev_cs_rise) begin
        bit_cnt <= '0;
      end else if (sel_active) begin
        if (ev_sample) begin
          rx_sh <= rx_next;
          if (last_bit) begin
            bit_cnt  <= '0;
            rx_data  <= rx_next;
            rx_valid <= 1'b1;
            echo_buf <= rx_next;
            tx_sh    <= byte_src;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else if (ev_launch) begin
          sdo   <= tx_sh[DATA_W-1];
          tx_sh <= shift_up(tx_sh);
        end
      end
    end
  end

endmodule

// File: rtl/spi_chain_tgt.sv
module spi_chain_tgt
  import spi_chain_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              chain_en_i,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  pin_bus_t pins_a, pins_s;
  logic [PIN_W-1:0] pins_s_raw;

  assign pins_a = '{cs_n: cs_n_i, sclk: sclk_i, sdi: sdi_i};

  spi_in_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_a),
    .sync_o  (pins_s_raw)
  );

  assign pins_s = pin_bus_t'(pins_s_raw);

  logic ev_sample, ev_launch, ev_cs_fall, ev_cs_rise, sel_active, sdi_bit;
  logic ev_byte_done, frame_src_msb;

  spi_edge_decode u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_s     (pins_s),
    .cpol       (cpol_i),
    .cpha       (cpha_i),
    .ev_sample  (ev_sample),
    .ev_launch  (ev_launch),
    .ev_cs_fall (ev_cs_fall),
    .ev_cs_rise (ev_cs_rise),
    .sel_active (sel_active),
    .sdi_bit    (sdi_bit)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpha          (cpha_i),
    .chain_en      (chain_en_i),
    .ev_sample     (ev_sample),
    .ev_launch     (ev_launch),
    .ev_cs_fall    (ev_cs_fall),
    .ev_cs_rise    (ev_cs_rise),
    .sel_active    (sel_active),
    .sdi_bit       (sdi_bit),
    .tx_data       (tx_data_i),
    .tx_load       (tx_load_i),
    .sdo           (sdo_o),
    .rx_data       (rx_data_o),
    .rx_valid      (rx_valid_o),
    .ev_byte_done  (ev_byte_done),
    .frame_src_msb (frame_src_msb)
  );

endmodule

// File: rtl/spi_chain_tgt_chk.sv
module spi_chain_tgt_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpha_i,
  input logic              ev_sample,
  input logic              ev_launch,
  input logic              ev_cs_fall,
  input logic              ev_cs_rise,
  input logic              sel_active,
  input logic              frame_src_msb,
  input logic              sdo_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_valid_o
);

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r3_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(ev_sample));

  a_r4_cs_fall_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cs_fall && !cpha_i) |=> (sdo_o == $past(frame_src_msb)));

  a_r5_sdo_moves_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_launch && !ev_cs_fall) |=> $stable(sdo_o));

  a_r6_idle_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> ($stable(rx_data_o) && !rx_valid_o));

  a_r7_no_valid_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_rise |=> !rx_valid_o);

endmodule

bind spi_chain_tgt spi_chain_tgt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpha_i        (cpha_i),
  .ev_sample     (ev_sample),
  .ev_launch     (ev_launch),
  .ev_cs_fall    (ev_cs_fall),
  .ev_cs_rise    (ev_cs_rise),
  .sel_active    (sel_active),
  .frame_src_msb (frame_src_msb),
  .sdo_o         (sdo_o),
  .rx_data_o     (rx_data_o),
  .rx_valid_o    (rx_valid_o)
);

// File: tb/spi_chain_tgt_tb.sv
`timescale 1ns/1ps
module spi_chain_tgt_tb_top;

  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, chain_en = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_load = 1'b0;
  logic sdo;
  logic [7:0] rx_data;
  logic rx_valid;

  always #4 clk = ~clk;

  spi_chain_tgt dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpol_i     (cpol),
    .cpha_i     (cpha),
    .chain_en_i (chain_en),
    .sclk_i     (sclk),
    .cs_n_i     (cs_n),
    .sdi_i      (sdi),
    .sdo_o      (sdo),
    .tx_data_i  (tx_data),
    .tx_load_i  (tx_load),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid)
  );

  int compared = 0;
  int mismatched = 0;
  int vcount = 0;
  logic done = 1'b0;
  logic held_sdo;

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model: pins seen through two flops, events acted on in order.
  logic [2:0] h1, h2, h3;
  logic m_sdo, m_valid, model_ok = 1'b0;
  int m_rx, m_hold, m_last, m_cnt, m_acc;
  logic txq[$];

  task automatic push_byte(input int b);
    txq.delete();
    for (int i = 7; i >= 0; i--) txq.push_back(b[i]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 3'b100; h2 = 3'b100; h3 = 3'b100;
      m_sdo = 0; m_valid = 0; m_rx = 0; m_hold = 0; m_last = 0;
      m_cnt = 0; m_acc = 0; txq.delete(); model_ok = 1'b1;
    end else begin
      logic cs_now, cs_old, sk, sk_old, din, lead, trail;
      cs_now = h2[2]; cs_old = h3[2]; sk = h2[1]; sk_old = h3[1]; din = h2[0];
      lead  = cpol ? (sk_old & ~sk) : (~sk_old & sk);
      trail = cpol ? (~sk_old & sk) : (sk_old & ~sk);
      m_valid = 0;
      if (!cs_now && cs_old) begin
        m_cnt = 0;
        push_byte(chain_en ? m_last : m_hold);
        if (!cpha) m_sdo = txq.pop_front();
      end else if (cs_now && !cs_old) begin
        m_cnt = 0;
      end else if (!cs_now) begin
        if (cpha ? trail : lead) begin
          m_acc = ((m_acc << 1) | int'(din)) & 255;
          m_cnt++;
          if (m_cnt == 8) begin
            m_cnt = 0; m_rx = m_acc; m_valid = 1; m_last = m_acc;
            push_byte(chain_en ? m_acc : m_hold);
          end
        end else if (cpha ? lead : trail) begin
          m_sdo = (txq.size() > 0) ? txq.pop_front() : 1'b0;
        end
      end
      if (tx_load) m_hold = int'(tx_data);
      h3 = h2; h2 = h1; h1 = {cs_n, sclk, sdi};
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_ok && !done) begin
      chk("R10", {m_sdo, m_valid, m_rx[7:0]}, {sdo, rx_valid, rx_data}, "per-cycle model sdo/valid/rx");
    end
  end

  always @(posedge clk) if (rst_n && rx_valid) vcount++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cpol = pol; cpha = pha; sclk = pol;
    wait_n(8);
  endtask

  task automatic load(input logic [7:0] b);
    tx_data = b; tx_load = 1'b1; wait_n(1); tx_load = 1'b0; wait_n(2);
  endtask

  task automatic xfer(input int nbits, input logic [31:0] mosi, output logic [31:0] miso);
    miso = '0;
    cs_n = 1'b0;
    wait_n(H);
    for (int i = nbits - 1; i >= 0; i--) begin
      if (!cpha) begin
        sdi = mosi[i]; wait_n(H);
        miso[i] = sdo;
        sclk = ~cpol; wait_n(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol; sdi = mosi[i]; wait_n(H);
        miso[i] = sdo;
        sclk = cpol; wait_n(H);
      end
    end
    wait_n(H);
    held_sdo = sdo;
    cs_n = 1'b1;
    wait_n(2 * H);
  endtask

  task automatic byte_mode(input logic pol, input logic pha, input logic [7:0] tx,
                           input logic [7:0] rxb, input string txtag);
    logic [31:0] got;
    int v0;
    set_mode(pol, pha);
    load(tx);
    v0 = vcount;
    xfer(8, {24'h0, rxb}, got);
    chk("R2", {24'h0, rx_data}, {24'h0, rxb}, "received byte for mode");
    chk("R3", vcount - v0, 1, "valid strobes per byte");
    chk(txtag, got, {24'h0, tx}, "byte seen on data-out");
    if (pha) chk("R5", {31'h0, held_sdo}, {31'h0, tx[0]}, "last bit held until select rises");
  endtask

  initial begin
    logic [31:0] got;
    int v0;
    logic s0;
    logic [7:0] r0;
    wait_n(5);
    chk("R1", {30'h0, sdo, rx_valid}, 32'h0, "outputs in reset");
    chk("R1", {24'h0, rx_data}, 32'h0, "rx byte in reset");
    rst_n = 1'b1;
    wait_n(4);
    chk("R1", {23'h0, sdo, rx_valid, rx_data}, 32'h0, "outputs after reset");

    // Nothing loaded yet: zeros go out.
    set_mode(1'b0, 1'b0);
    v0 = vcount;
    xfer(8, 32'hA5, got);
    chk("R8", got, 32'h0, "default transmit byte before any load");
    chk("R3", {24'h0, rx_data}, 32'hA5, "received byte msb first");
    chk("R3", vcount - v0, 1, "one valid strobe");

    byte_mode(1'b0, 1'b0, 8'h3C, 8'h5A, "R4");
    byte_mode(1'b0, 1'b1, 8'hC3, 8'h96, "R5");
    byte_mode(1'b1, 1'b0, 8'h81, 8'h7E, "R4");
    byte_mode(1'b1, 1'b1, 8'h42, 8'hBD, "R5");

    // R6: clock activity with select high.
    s0 = sdo; r0 = rx_data; v0 = vcount;
    for (int k = 0; k < 12; k++) begin
      sclk = ~sclk; sdi = k[0]; wait_n(H);
    end
    sclk = cpol; wait_n(2 * H);
    chk("R6", {31'h0, sdo}, {31'h0, s0}, "data-out while deselected");
    chk("R6", {24'h0, rx_data}, {24'h0, r0}, "rx byte while deselected");
    chk("R6", vcount - v0, 0, "no strobe while deselected");

    // R7: aborted partial byte, then a clean byte.
    set_mode(1'b0, 1'b0);
    load(8'hF0);
    r0 = rx_data; v0 = vcount;
    xfer(5, 32'h16, got);
    chk("R7", vcount - v0, 0, "no strobe for partial byte");
    chk("R7", {24'h0, rx_data}, {24'h0, r0}, "rx byte kept after abort");
    v0 = vcount;
    xfer(8, 32'h69, got);
    chk("R7", {24'h0, rx_data}, 32'h69, "fresh byte after abort");
    chk("R7", got, 32'hF0, "transmit restarts at first bit");
    chk("R3", vcount - v0, 1, "strobe after abort");

    // Two groups in one select period, chain off.
    load(8'h55);
    v0 = vcount;
    xfer(16, 32'h1234, got);
    chk("R8", got, 32'h5555, "loaded byte repeated per group");
    chk("R3", vcount - v0, 2, "two strobes in 16 bits");
    chk("R3", {24'h0, rx_data}, 32'h34, "second byte received");

    // R9: chain mode echoes the previous group.
    chain_en = 1'b1;
    wait_n(4);
    xfer(24, 32'hA1B2C3, got);
    chk("R9", got, 32'h34A1B2, "chain echo across three groups");
    set_mode(1'b1, 1'b1);
    xfer(8, 32'hD4, got);
    chk("R9", got, 32'hC3, "chain echo across select periods, mode 3");
    chk("R2", {24'h0, rx_data}, 32'hD4, "chain receive mode 3");

    wait_n(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule